// File: doc/BRIEF.md
# Pattern Monitor Status Latching and Interrupt Summary

This block sits beside a bit-error-rate pattern monitor. It takes three live indications from the monitor: a level saying the monitor has lost lock to the incoming pattern, a level saying its error counter is non-zero, and a one-cycle strobe for every bit error found. It passes the two levels straight through as live status. Each of the three indications also feeds its own sticky flag, which keeps a record until software clears it.

The flags do not share one trigger rule. The lock-loss flag records any change of the lock-loss level, in either direction. The counter flag records only a rise of the non-zero level. The error flag records every strobe. A small write port clears flags by writing ones (write-one-to-clear) and loads a three-bit interrupt enable register. A single summary interrupt is raised while any flag and its enable are both set.

Each sticky flag is a two-state machine with states FLAG_CLEAR and FLAG_SET. The transition SET_EVENT moves FLAG_CLEAR to FLAG_SET when the flag's trigger fires. The transition CLEAR_WRITE moves FLAG_SET to FLAG_CLEAR when a clear is written and no trigger fires in the same cycle. In every other case the machine holds its state. A trigger in the same cycle as a clear keeps the flag set.

Top module: `bert_status_irq`

## Requirements
- R1: After reset, `latched`, `enables` and `irq` are all zero. The trigger history registers also reset to zero, so with inputs low no flag sets when reset is released.
- R2: `live_status[0]` equals `live_oos` and `live_status[1]` equals `live_errcnt_nz`, both combinationally.
- R3: `latched[0]` sets on the clock edge at which `live_oos` differs from its value at the previous edge (or from 0 at the first edge after reset), in either direction.
- R4: `latched[1]` sets only on the edge at which `live_errcnt_nz` is 1 and was 0 at the previous edge. A fall, or a level held at 1, does not set it.
- R5: `latched[2]` sets on every edge at which `bit_err_evt` is 1.
- R6: A write with `wr_en`=1 and `wr_addr`=0 clears each `latched` bit whose `wr_data` bit is 1 and leaves the other bits unchanged. If that bit's trigger fires in the same cycle, the bit stays set.
- R7: A write with `wr_en`=1 and `wr_addr`=1 loads `wr_data` into `enables` at that edge. Bit i of `enables` enables flag i.
- R8: `irq` is 1 exactly when some bit i has both `latched[i]`=1 and `enables[i]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| live_oos | input | 1 | Monitor not locked to the pattern |
| live_errcnt_nz | input | 1 | Monitor error count is above zero |
| bit_err_evt | input | 1 | One-cycle strobe per detected bit error |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0: clear flags (write-one), 1: load enables |
| wr_data | input | 3 | Write data, bit i addresses flag i |
| live_status | output | 2 | {count non-zero, out of lock} |
| latched | output | 3 | Sticky flags {bit error, count rise, lock change} |
| enables | output | 3 | Interrupt enables |
| irq | output | 1 | Summary interrupt |

## Verification
Directed sequences apply each input pattern on its own:
- A lock-loss level that rises and then falls tells the any-change flag apart from a set-on-high flag.
- A count level that rises, holds and then falls shows that only the rise records anything.
- An error strobe applied together with a clear write shows which of the two wins.

Enable patterns that cover one flag and none check that the summary interrupt follows the enabled flags only. A long random mix of levels, strobes and writes then compares every output, each cycle, against a bench model. That model holds its own history of the previous input values.

// File: rtl/bsi_pkg.sv
package bsi_pkg;

    localparam int unsigned FLAG_N = 3;
    localparam int unsigned LIVE_N = 2;

    localparam logic ADDR_CLEAR  = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;

    typedef enum logic [1:0] {
        TRIG_ANY_EDGE,
        TRIG_RISE,
        TRIG_PULSE
    } trig_e;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_e;

    function automatic trig_e trig_of(input int unsigned idx);
        case (idx)
            0:       return TRIG_ANY_EDGE;
            1:       return TRIG_RISE;
            default: return TRIG_PULSE;
        endcase
    endfunction

endpackage

// File: rtl/bsi_trigger.sv
module bsi_trigger #(
    parameter bsi_pkg::trig_e MODE = bsi_pkg::TRIG_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic fire
);

    generate
        if (MODE == bsi_pkg::TRIG_PULSE) begin : g_pulse
            always_comb fire = src;
        end else begin : g_edge
            logic prev_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                end else begin
                    prev_q <= src;
                end
            end

            if (MODE == bsi_pkg::TRIG_RISE) begin : g_rise
                always_comb fire = src & ~prev_q;
            end else begin : g_any
                always_comb fire = src ^ prev_q;
            end
        end
    endgenerate

endmodule

// File: rtl/bsi_sticky_flag.sv
module bsi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic held
);

    bsi_pkg::flag_state_e state_q;
    bsi_pkg::flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= bsi_pkg::FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held    = 1'b0;
        unique case (state_q)
            bsi_pkg::FLAG_CLEAR: begin
                if (set_evt) begin
                    state_d = bsi_pkg::FLAG_SET;
                end
            end
            bsi_pkg::FLAG_SET: begin
                held = 1'b1;
                if (clr_req && !set_evt) begin
                    state_d = bsi_pkg::FLAG_CLEAR;
                end
            end
        endcase
    end

endmodule

// File: rtl/bsi_enable_reg.sv
module bsi_enable_reg #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/bsi_irq_merge.sv
module bsi_irq_merge #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic         irq
);

    always_comb irq = |(flags & mask);

endmodule

// File: rtl/bert_status_irq.sv
module bert_status_irq (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       live_oos,
    input  logic                       live_errcnt_nz,
    input  logic                       bit_err_evt,
    input  logic                       wr_en,
    input  logic                       wr_addr,
    input  logic [bsi_pkg::FLAG_N-1:0] wr_data,
    output logic [bsi_pkg::LIVE_N-1:0] live_status,
    output logic [bsi_pkg::FLAG_N-1:0] latched,
    output logic [bsi_pkg::FLAG_N-1:0] enables,
    output logic                       irq
);

    localparam int unsigned N = bsi_pkg::FLAG_N;

    logic [N-1:0] src_vec;
    logic [N-1:0] fire_vec;
    logic [N-1:0] clr_vec;
    logic         en_load;

    always_comb begin
        live_status = {live_errcnt_nz, live_oos};
        src_vec     = {bit_err_evt, live_errcnt_nz, live_oos};
        clr_vec     = (wr_en && wr_addr == bsi_pkg::ADDR_CLEAR) ? wr_data : '0;
        en_load     = wr_en && wr_addr == bsi_pkg::ADDR_ENABLE;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            bsi_trigger #(
                .MODE(bsi_pkg::trig_of(i))
            ) u_trig (
                .clk  (clk),
                .rst_n(rst_n),
                .src  (src_vec[i]),
                .fire (fire_vec[i])
            );

            bsi_sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_evt(fire_vec[i]),
                .clr_req(clr_vec[i]),
                .held   (latched[i])
            );
        end
    endgenerate

    bsi_enable_reg #(.N(N)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .load (en_load),
        .din  (wr_data),
        .q    (enables)
    );

    bsi_irq_merge #(.N(N)) u_irq (
        .flags(latched),
        .mask (enables),
        .irq  (irq)
    );

endmodule

// File: rtl/bert_status_irq_chk.sv
module bert_status_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       live_oos,
    input logic       live_errcnt_nz,
    input logic       bit_err_evt,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [2:0] wr_data,
    input logic [2:0] latched,
    input logic [2:0] enables,
    input logic       irq
);

    logic prv_oos;
    logic prv_nz;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_oos <= 1'b0;
            prv_nz  <= 1'b0;
        end else begin
            prv_oos <= live_oos;
            prv_nz  <= live_errcnt_nz;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (latched == 3'b000 && enables == 3'b000 && !irq));

    p_oos_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_oos != prv_oos) |=> latched[0]);

    p_nz_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_errcnt_nz && !prv_nz) |=> latched[1]);

    p_nz_norise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched[1] && !(live_errcnt_nz && !prv_nz)) |=> !latched[1]);

    p_biterr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err_evt |=> latched[2]);

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[2] && !bit_err_evt) |=> !latched[2]);

    p_enable_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (enables == $past(wr_data)));

    p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(latched & enables)) |-> irq);

    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latched & enables) == 3'b000 |-> !irq);

endmodule

bind bert_status_irq bert_status_irq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .live_oos      (live_oos),
    .live_errcnt_nz(live_errcnt_nz),
    .bit_err_evt   (bit_err_evt),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .latched       (latched),
    .enables       (enables),
    .irq           (irq)
);

// File: tb/bert_status_irq_tb_top.sv
`timescale 1ns/1ps
module bert_status_irq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       live_oos = 1'b0;
    logic       live_errcnt_nz = 1'b0;
    logic       bit_err_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic [1:0] live_status;
    logic [2:0] latched;
    logic [2:0] enables;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [2:0] m_lat = 3'b000;
    logic [2:0] m_en = 3'b000;
    logic       m_poos = 1'b0;
    logic       m_pnz = 1'b0;

    always #4 clk = ~clk;

    bert_status_irq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .live_oos      (live_oos),
        .live_errcnt_nz(live_errcnt_nz),
        .bit_err_evt   (bit_err_evt),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .live_status   (live_status),
        .latched       (latched),
        .enables       (enables),
        .irq           (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] fire_of(input logic oos, input logic nz, input logic be,
                                           input logic poos, input logic pnz);
        return {be, nz & ~pnz, oos ^ poos};
    endfunction

    function automatic logic [2:0] next_lat(input logic [2:0] lat, input logic [2:0] fire,
                                            input logic [2:0] clr);
        return (lat & ~clr) | fire;
    endfunction

    task automatic compare_all();
        check("R2 live_status", {30'd0, live_status}, {30'd0, live_errcnt_nz, live_oos});
        check("R3 latched[0]", {31'd0, latched[0]}, {31'd0, m_lat[0]});
        check("R4 latched[1]", {31'd0, latched[1]}, {31'd0, m_lat[1]});
        check("R5 latched[2]", {31'd0, latched[2]}, {31'd0, m_lat[2]});
        check("R7 enables", {29'd0, enables}, {29'd0, m_en});
        check("R8 irq", {31'd0, irq}, {31'd0, |(m_lat & m_en)});
    endtask

    task automatic cycle(input logic oos, input logic nz, input logic be,
                         input logic we, input logic wa, input logic [2:0] wd);
        logic [2:0] clr;
        @(negedge clk);
        live_oos = oos; live_errcnt_nz = nz; bit_err_evt = be;
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        clr = (we && !wa) ? wd : 3'b000;
        m_lat = next_lat(m_lat, fire_of(oos, nz, be, m_poos, m_pnz), clr);
        if (we && wa) m_en = wd;
        m_poos = oos;
        m_pnz = nz;
        #1;
        compare_all();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset latched", {29'd0, latched}, 32'd0);
        check("R1 reset enables", {29'd0, enables}, 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no spurious set when reset releases with inputs low
        cycle(0, 0, 0, 0, 0, 3'b000);
        check("R1 no spurious flag", {29'd0, latched}, 32'd0);

        // R3: rise of lock-loss sets, clear, then fall sets again
        cycle(1, 0, 0, 0, 0, 3'b000);
        check("R3 rise sets", {29'd0, latched}, 32'd1);
        cycle(1, 0, 0, 1, 0, 3'b001);
        check("R6 clear flag0", {29'd0, latched}, 32'd0);
        cycle(1, 0, 0, 0, 0, 3'b000);
        check("R3 steady high no set", {29'd0, latched}, 32'd0);
        cycle(0, 0, 0, 0, 0, 3'b000);
        check("R3 fall sets", {29'd0, latched}, 32'd1);
        cycle(0, 0, 0, 1, 0, 3'b111);

        // R4: rise sets, hold and fall do not
        cycle(0, 1, 0, 0, 0, 3'b000);
        check("R4 rise sets", {29'd0, latched}, 32'd2);
        cycle(0, 1, 0, 1, 0, 3'b010);
        cycle(0, 1, 0, 0, 0, 3'b000);
        check("R4 held high no set", {29'd0, latched}, 32'd0);
        cycle(0, 0, 0, 0, 0, 3'b000);
        check("R4 fall no set", {29'd0, latched}, 32'd0);

        // R5 and R6: strobe sets, strobe with clear keeps it set
        cycle(0, 0, 1, 0, 0, 3'b000);
        check("R5 strobe sets", {29'd0, latched}, 32'd4);
        cycle(0, 0, 1, 1, 0, 3'b100);
        check("R6 set wins over clear", {29'd0, latched}, 32'd4);
        cycle(0, 0, 0, 1, 0, 3'b011);
        check("R6 unselected bit kept", {29'd0, latched}, 32'd4);

        // R7 and R8: enable pattern selects interrupt
        cycle(0, 0, 0, 1, 1, 3'b011);
        check("R7 enables loaded", {29'd0, enables}, 32'd3);
        check("R8 masked flag no irq", {31'd0, irq}, 32'd0);
        cycle(0, 0, 0, 1, 1, 3'b100);
        check("R8 enabled flag irq", {31'd0, irq}, 32'd1);
        cycle(0, 0, 0, 1, 0, 3'b100);
        check("R8 cleared flag irq off", {31'd0, irq}, 32'd0);

        for (int n = 0; n < 3000; n++) begin
            logic we;
            we = ($urandom % 4) == 0;
            cycle(($urandom % 8) == 0 ? ~live_oos : live_oos,
                  ($urandom % 6) == 0 ? ~live_errcnt_nz : live_errcnt_nz,
                  ($urandom % 5) == 0,
                  we, $urandom % 2, 3'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule